// File: doc/BRIEF.md
# Software-Loaded Address Translation Buffer

This block translates 32-bit virtual addresses into physical addresses for a processor whose page tables are managed entirely by software. It holds a fully associative set of page translations for 4 KiB pages. Each translation carries an address-space tag, a flag that bypasses the tag compare for shared pages, a write-enable flag, a valid flag and an uncached flag. A lookup is resolved in the same cycle it is presented. It returns the physical address or one of three faults: no matching entry, a store to a page that is not write-enabled, or a user-mode reference to the upper half of the address map.

Software fills the buffer through a pair of 32-bit staging words, a high word holding the page number and tag and a low word holding the frame number and flags. It can place an entry at a slot it names, or at a slot taken from a free-running down-counter. That counter never lands on the lowest slots, so those slots can hold pinned mappings. The same staging high word also drives a continuous search port, which reports the lowest slot holding a matching translation, or reports that none exists.

Two kernel windows skip translation entirely: 0x8000_0000–0x9FFF_FFFF and 0xA000_0000–0xBFFF_FFFF. Both map to physical memory by clearing address bits 31:29, and the second window is reported as uncached. The lookup path has a request valid and a response valid but no ready. The block accepts a request in every cycle, and the response sits on the outputs in the same cycle, so no back-pressure exists.

Top module: `tlb_xlate`

## Requirements
- R1: While reset is held, every slot is invalid and the random slot counter reads ENTRIES-1 (63). After reset, every lookup in the mapped regions misses and every search reports not-found.
- R2: A lookup of a mapped address hits when some slot meets three conditions: it is valid, its page number equals vaddr[31:12], and either its tag equals lk_asid or its shared flag is set. On a hit, lk_paddr is {frame number, vaddr[11:0]}.
- R3: A store that hits a slot whose write-enable flag is clear raises lk_modf and does not raise lk_ok.
- R4: A successful mapped lookup drives lk_uncached from the slot's uncached flag.
- R5: In kernel mode, addresses with bits 31:30 = 2'b10 bypass the slots. The result is lk_ok with lk_paddr = {3'b000, vaddr[28:0]}. lk_uncached is set exactly when bit 29 is 1.
- R6: In user mode, any address with bit 31 set raises lk_aerr and performs no lookup.
- R7: The search port matches sw_hi against all slots under the R2 rule. It uses sw_hi as page number and tag. It returns the lowest matching slot on prb_index, or raises prb_notfound when no slot matches.
- R8: A pulse on sw_wr_index stores the staging pair into slot sw_index at the next rising edge. The high word holds page number in bits 31:12 and tag in bits 11:6. The low word holds frame number in bits 31:12 and the flags uncached, write-enable, valid and shared in bits 11, 10, 9 and 8. Storing an entry with valid clear invalidates the slot.
- R9: The random slot counter steps down by one every cycle from ENTRIES-1 to WIRED (8), then wraps to ENTRIES-1. A pulse on sw_wr_random stores the staging pair into the slot the counter shows during that cycle. If both write pulses are present, the indexed write wins.
- R10: When several slots match a lookup, the lowest-numbered slot supplies the translation.
- R11: lk_resp_valid follows lk_valid. With lk_valid high, exactly one of lk_ok, lk_miss, lk_modf and lk_aerr is set. With lk_valid low, none of them is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request present |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_store | input | 1 | Request is a store |
| lk_user | input | 1 | Request is issued in user mode |
| lk_asid | input | 6 | Current address-space tag |
| lk_resp_valid | output | 1 | Lookup response present |
| lk_ok | output | 1 | Translation succeeded |
| lk_miss | output | 1 | No matching slot |
| lk_modf | output | 1 | Store to a page that is not write-enabled |
| lk_aerr | output | 1 | User access to the kernel half |
| lk_uncached | output | 1 | Access must bypass caches |
| lk_paddr | output | 32 | Physical address |
| sw_hi | input | 32 | Staging high word (page number, tag); also the search key |
| sw_lo | input | 32 | Staging low word (frame number, flags) |
| sw_wr_index | input | 1 | Store staging pair at sw_index |
| sw_wr_random | input | 1 | Store staging pair at rand_idx |
| sw_index | input | 6 | Target slot of an indexed store |
| prb_notfound | output | 1 | Search found no match |
| prb_index | output | 6 | Lowest matching slot of the search |
| rand_idx | output | 6 | Current random slot |

## Verification
Lookup and search results are combinational. Each is due in the cycle its inputs are applied, so the bench drives inputs after a falling edge and samples one time unit later with no clock edge in between. A store through either write pulse becomes visible only after the next rising edge. The bench therefore holds the pulse across one rising edge, clears it at the following falling edge, and reads the search port after that. The random counter moves once per rising edge. The bench records it at every falling edge and compares each value with the one recorded a cycle earlier, minus one or wrapped.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VPN_W  = 20;
  localparam int PFN_W  = 20;
  localparam int ASID_W = 6;
  localparam int OFS_W  = 12;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic [PFN_W-1:0]  pfn;
    logic              nc;
    logic              we;
    logic              vld;
    logic              shr;
  } tlb_slot_t;

  function automatic tlb_slot_t unpack_pair(input logic [31:0] hi, input logic [31:0] lo);
    tlb_slot_t s;
    s.vpn  = hi[31:12];
    s.asid = hi[11:6];
    s.pfn  = lo[31:12];
    s.nc   = lo[11];
    s.we   = lo[10];
    s.vld  = lo[9];
    s.shr  = lo[8];
    return s;
  endfunction
endpackage

// File: rtl/tlb_rand.sv
module tlb_rand #(
  parameter int ENTRIES = 64,
  parameter int WIRED   = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] TOP = IDX_W'(ENTRIES - 1);
  localparam logic [IDX_W-1:0] BOT = IDX_W'(WIRED);

  always_ff @(posedge clk) begin
    if (!rst_n)          idx <= TOP;
    else if (idx == BOT) idx <= TOP;
    else                 idx <= idx - 1'b1;
  end
endmodule

// File: rtl/tlb_cam.sv
module tlb_cam
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  tlb_slot_t          slots [ENTRIES],
  input  logic [VPN_W-1:0]   key_vpn,
  input  logic [ASID_W-1:0]  key_asid,
  output logic               found,
  output logic [IDX_W-1:0]   idx
);
  logic [ENTRIES-1:0] match;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign match[i] = slots[i].vld && (slots[i].vpn == key_vpn) &&
                      (slots[i].shr || (slots[i].asid == key_asid));
  end

  // Scan from the top so the lowest matching slot is the last one assigned.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/tlb_seg.sv
module tlb_seg (
  input  logic [2:0] va_top,
  input  logic       user,
  output logic       aerr,
  output logic       bypass,
  output logic       seg_uncached
);
  assign aerr         = user && va_top[2];
  assign bypass       = !user && (va_top[2:1] == 2'b10);
  assign seg_uncached = va_top[0];
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int WIRED   = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [31:0]       lk_vaddr,
  input  logic              lk_store,
  input  logic              lk_user,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              lk_resp_valid,
  output logic              lk_ok,
  output logic              lk_miss,
  output logic              lk_modf,
  output logic              lk_aerr,
  output logic              lk_uncached,
  output logic [31:0]       lk_paddr,
  input  logic [31:0]       sw_hi,
  input  logic [31:0]       sw_lo,
  input  logic              sw_wr_index,
  input  logic              sw_wr_random,
  input  logic [IDX_W-1:0]  sw_index,
  output logic              prb_notfound,
  output logic [IDX_W-1:0]  prb_index,
  output logic [IDX_W-1:0]  rand_idx
);
  tlb_slot_t        slots_q [ENTRIES];
  tlb_slot_t        new_slot;
  logic [IDX_W-1:0] wsel;
  logic             wen;
  logic             lk_found;
  logic [IDX_W-1:0] lk_idx;
  logic             prb_found;
  logic             seg_aerr, seg_bypass, seg_unc;
  tlb_slot_t        hit_slot;
  logic             spare_bits_unused;

  assign spare_bits_unused = ^{sw_hi[5:0], sw_lo[7:0]};

  tlb_rand #(.ENTRIES(ENTRIES), .WIRED(WIRED)) u_rand (
    .clk(clk), .rst_n(rst_n), .idx(rand_idx)
  );

  assign new_slot = unpack_pair(sw_hi, sw_lo);
  assign wen      = sw_wr_index || sw_wr_random;
  assign wsel     = sw_wr_index ? sw_index : rand_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) slots_q[i] <= '0;
    end else if (wen) begin
      for (int i = 0; i < ENTRIES; i++)
        if (wsel == IDX_W'(i)) slots_q[i] <= new_slot;
    end
  end

  tlb_cam #(.ENTRIES(ENTRIES)) u_cam_lk (
    .slots(slots_q), .key_vpn(lk_vaddr[31:12]), .key_asid(lk_asid),
    .found(lk_found), .idx(lk_idx)
  );

  tlb_cam #(.ENTRIES(ENTRIES)) u_cam_prb (
    .slots(slots_q), .key_vpn(sw_hi[31:12]), .key_asid(sw_hi[11:6]),
    .found(prb_found), .idx(prb_index)
  );
  assign prb_notfound = !prb_found;

  tlb_seg u_seg (
    .va_top(lk_vaddr[31:29]), .user(lk_user),
    .aerr(seg_aerr), .bypass(seg_bypass), .seg_uncached(seg_unc)
  );

  assign hit_slot      = slots_q[lk_idx];
  assign lk_resp_valid = lk_valid;

  always_comb begin
    lk_ok       = 1'b0;
    lk_miss     = 1'b0;
    lk_modf     = 1'b0;
    lk_aerr     = 1'b0;
    lk_uncached = 1'b0;
    lk_paddr    = '0;
    if (lk_valid) begin
      if (seg_aerr) begin
        lk_aerr = 1'b1;
      end else if (seg_bypass) begin
        lk_ok       = 1'b1;
        lk_paddr    = {3'b000, lk_vaddr[28:0]};
        lk_uncached = seg_unc;
      end else if (!lk_found) begin
        lk_miss = 1'b1;
      end else if (lk_store && !hit_slot.we) begin
        lk_modf = 1'b1;
      end else begin
        lk_ok       = 1'b1;
        lk_paddr    = {hit_slot.pfn, lk_vaddr[OFS_W-1:0]};
        lk_uncached = hit_slot.nc;
      end
    end
  end
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter int ENTRIES = 64,
  parameter int WIRED   = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic [31:0]      lk_vaddr,
  input logic             lk_user,
  input logic             lk_resp_valid,
  input logic             lk_ok,
  input logic             lk_miss,
  input logic             lk_modf,
  input logic             lk_aerr,
  input logic             lk_uncached,
  input logic [31:0]      lk_paddr,
  input logic [IDX_W-1:0] rand_idx
);
  a_r11_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> ($countones({lk_ok, lk_miss, lk_modf, lk_aerr}) == 1) && lk_resp_valid);

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> ($countones({lk_ok, lk_miss, lk_modf, lk_aerr}) == 0) && !lk_resp_valid);

  a_r6_user_kernel_half: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_user && lk_vaddr[31]) |-> lk_aerr);

  a_r5_bypass_window: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !lk_user && lk_vaddr[31:30] == 2'b10) |->
      lk_ok && (lk_paddr == {3'b000, lk_vaddr[28:0]}) && (lk_uncached == lk_vaddr[29]));

  a_r9_rand_floor: assert property (@(posedge clk) disable iff (!rst_n)
    rand_idx >= IDX_W'(WIRED));

  a_r9_rand_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rand_idx != IDX_W'(WIRED)) |=> (rand_idx == $past(rand_idx) - 1'b1));

  a_r9_rand_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (rand_idx == IDX_W'(WIRED)) |=> (rand_idx == IDX_W'(ENTRIES - 1)));
endmodule

bind tlb_xlate tlb_xlate_chk #(.ENTRIES(ENTRIES), .WIRED(WIRED)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
  .lk_user(lk_user), .lk_resp_valid(lk_resp_valid), .lk_ok(lk_ok),
  .lk_miss(lk_miss), .lk_modf(lk_modf), .lk_aerr(lk_aerr),
  .lk_uncached(lk_uncached), .lk_paddr(lk_paddr), .rand_idx(rand_idx)
);

// File: tb/tb_tlb_xlate.sv
module tb_tlb_xlate;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0, lk_store = 1'b0, lk_user = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic [5:0]  lk_asid = '0;
  logic        lk_resp_valid, lk_ok, lk_miss, lk_modf, lk_aerr, lk_uncached;
  logic [31:0] lk_paddr;
  logic [31:0] sw_hi = '0, sw_lo = '0;
  logic        sw_wr_index = 1'b0, sw_wr_random = 1'b0;
  logic [5:0]  sw_index = '0;
  logic        prb_notfound;
  logic [5:0]  prb_index, rand_idx;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_xlate dut (.*);

  function automatic logic [31:0] mk_hi(input logic [19:0] vpn, input logic [5:0] asid);
    return {vpn, asid, 6'b0};
  endfunction
  function automatic logic [31:0] mk_lo(input logic [19:0] pfn, input logic nc, we, v, g);
    return {pfn, nc, we, v, g, 8'b0};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_at(input logic [5:0] idx, input logic [31:0] hi, input logic [31:0] lo);
    @(negedge clk);
    sw_index = idx; sw_hi = hi; sw_lo = lo; sw_wr_index = 1'b1;
    @(negedge clk);
    sw_wr_index = 1'b0;
  endtask

  task automatic look(input logic [31:0] va, input logic [5:0] asid, input logic st, input logic usr);
    lk_valid = 1'b1; lk_vaddr = va; lk_asid = asid; lk_store = st; lk_user = usr;
    #1;
  endtask

  // Outcome vector: {ok, miss, modf, aerr, uncached, paddr}
  task automatic expect_look(input string req, input logic [3:0] flags,
                             input logic unc, input logic [31:0] pa);
    chk(req, {27'b0, lk_ok, lk_miss, lk_modf, lk_aerr, lk_uncached, lk_paddr},
             {27'b0, flags, unc, pa});
  endtask

  task automatic probe(input string req, input logic [31:0] hi, input logic nf, input logic [5:0] idx);
    sw_hi = hi; #1;
    chk(req, {57'b0, prb_notfound, prb_index}, {57'b0, nf, nf ? prb_index : idx});
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 rand at reset", {58'b0, rand_idx}, 64'd63);
    look(32'h1234_5678, 6'd0, 1'b0, 1'b0);
    expect_look("R1 empty lookup misses", 4'b0100, 1'b0, 32'h0);
    probe("R1 empty search", mk_hi(20'h12345, 6'd0), 1'b1, 6'd0);
    lk_valid = 1'b0; #1;
    chk("R11 idle quiet", {59'b0, lk_resp_valid, lk_ok, lk_miss, lk_modf, lk_aerr}, 64'd0);
  endtask

  task automatic t_hit_asid;
    write_at(6'd3, mk_hi(20'h12345, 6'd5), mk_lo(20'hABCDE, 1'b0, 1'b1, 1'b1, 1'b0));
    look(32'h1234_5678, 6'd5, 1'b0, 1'b0);
    expect_look("R2 hit paddr", 4'b1000, 1'b0, 32'hABCD_E678);
    chk("R11 resp follows valid", {63'b0, lk_resp_valid}, 64'd1);
    look(32'h1234_5ABC, 6'd5, 1'b1, 1'b1);
    expect_look("R2 user store hit", 4'b1000, 1'b0, 32'hABCD_EABC);
    look(32'h1234_5678, 6'd6, 1'b0, 1'b0);
    expect_look("R2 tag mismatch misses", 4'b0100, 1'b0, 32'h0);
    look(32'hC123_4000, 6'd5, 1'b0, 1'b0);
    expect_look("R2 upper mapped region misses", 4'b0100, 1'b0, 32'h0);
  endtask

  task automatic t_shared;
    write_at(6'd4, mk_hi(20'h00400, 6'd1), mk_lo(20'h00055, 1'b0, 1'b1, 1'b1, 1'b1));
    look(32'h0040_0010, 6'd9, 1'b0, 1'b1);
    expect_look("R2 shared ignores tag", 4'b1000, 1'b0, 32'h0005_5010);
    probe("R7 search shared", mk_hi(20'h00400, 6'd33), 1'b0, 6'd4);
    probe("R7 search tag miss", mk_hi(20'h12345, 6'd7), 1'b1, 6'd0);
    probe("R7 search hit", mk_hi(20'h12345, 6'd5), 1'b0, 6'd3);
  endtask

  task automatic t_readonly;
    write_at(6'd5, mk_hi(20'h00500, 6'd2), mk_lo(20'h00777, 1'b0, 1'b0, 1'b1, 1'b0));
    look(32'h0050_0004, 6'd2, 1'b0, 1'b1);
    expect_look("R3 load of read-only page", 4'b1000, 1'b0, 32'h0077_7004);
    look(32'h0050_0004, 6'd2, 1'b1, 1'b1);
    expect_look("R3 store raises modify fault", 4'b0010, 1'b0, 32'h0);
  endtask

  task automatic t_nocache;
    write_at(6'd2, mk_hi(20'hC0001, 6'd0), mk_lo(20'h00123, 1'b1, 1'b1, 1'b1, 1'b1));
    look(32'hC000_1FF0, 6'd0, 1'b0, 1'b0);
    expect_look("R4 uncached page flag", 4'b1000, 1'b1, 32'h0012_3FF0);
  endtask

  task automatic t_bypass;
    look(32'h8000_1234, 6'd0, 1'b0, 1'b0);
    expect_look("R5 cached window", 4'b1000, 1'b0, 32'h0000_1234);
    look(32'hBFFF_FFFC, 6'd0, 1'b1, 1'b0);
    expect_look("R5 uncached window", 4'b1000, 1'b1, 32'h1FFF_FFFC);
  endtask

  task automatic t_user_err;
    look(32'h8000_0000, 6'd0, 1'b0, 1'b1);
    expect_look("R6 user in cached window", 4'b0001, 1'b0, 32'h0);
    look(32'hC000_1000, 6'd0, 1'b1, 1'b1);
    expect_look("R6 user in mapped kernel half", 4'b0001, 1'b0, 32'h0);
    look(32'h7FFF_F000, 6'd0, 1'b0, 1'b1);
    expect_look("R6 top user page is looked up", 4'b0100, 1'b0, 32'h0);
  endtask

  task automatic t_invalidate;
    write_at(6'd3, mk_hi(20'h12345, 6'd5), mk_lo(20'hABCDE, 1'b0, 1'b1, 1'b0, 1'b0));
    look(32'h1234_5678, 6'd5, 1'b0, 1'b0);
    expect_look("R8 invalidated slot misses", 4'b0100, 1'b0, 32'h0);
    probe("R8 invalidated slot not found", mk_hi(20'h12345, 6'd5), 1'b1, 6'd0);
  endtask

  task automatic t_priority;
    write_at(6'd10, mk_hi(20'h00777, 6'd3), mk_lo(20'h0AAAA, 1'b0, 1'b1, 1'b1, 1'b0));
    write_at(6'd6,  mk_hi(20'h00777, 6'd3), mk_lo(20'h0BBBB, 1'b0, 1'b1, 1'b1, 1'b0));
    look(32'h0077_7100, 6'd3, 1'b0, 1'b0);
    expect_look("R10 lowest slot wins", 4'b1000, 1'b0, 32'h0BBB_B100);
    probe("R7 search returns lowest", mk_hi(20'h00777, 6'd3), 1'b0, 6'd6);
  endtask

  task automatic t_random;
    logic [5:0] prev, r;
    bit ok_seq = 1'b1;
    @(negedge clk); prev = rand_idx;
    for (int i = 0; i < 70; i++) begin
      @(negedge clk);
      r = rand_idx;
      if (r != ((prev == 6'd8) ? 6'd63 : prev - 6'd1) || r < 6'd8) begin
        ok_seq = 1'b0;
        $display("FAIL R9 step: actual=%0d expected after %0d", r, prev);
      end
      prev = r;
    end
    chk("R9 random sequence", {63'b0, ok_seq}, 64'd1);
    r = rand_idx;
    sw_hi = mk_hi(20'h0ABCD, 6'd0); sw_lo = mk_lo(20'h0FEED, 1'b0, 1'b1, 1'b1, 1'b0);
    sw_wr_random = 1'b1;
    @(negedge clk); sw_wr_random = 1'b0;
    probe("R9 random write lands at shown slot", mk_hi(20'h0ABCD, 6'd0), 1'b0, r);
    sw_hi = mk_hi(20'h0CCCC, 6'd0); sw_lo = mk_lo(20'h0DDDD, 1'b0, 1'b1, 1'b1, 1'b0);
    sw_index = 6'd1; sw_wr_index = 1'b1; sw_wr_random = 1'b1;
    @(negedge clk); sw_wr_index = 1'b0; sw_wr_random = 1'b0;
    probe("R9 indexed wins over random", mk_hi(20'h0CCCC, 6'd0), 1'b0, 6'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_hit_asid();
    t_shared();
    t_readonly();
    t_nocache();
    t_bypass();
    t_user_err();
    t_invalidate();
    t_priority();
    t_random();
    lk_valid = 1'b0;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule